// File: doc/BRIEF.md
# Miss Tracking Entry with Deferred Target List

This block is one tracking entry of a non-blocking cache's miss file. When a miss is allocated, the entry captures the line address, request size, an exclusivity requirement, a global order stamp and a ready time. It then collects the requests that wait on the same line. Each waiting request, called a target, holds its arrival time, its order stamp, whether it came from the CPU side or the memory side (snoop), and whether it wanted exclusive access.

Once the request has gone out (in service), some late arrivals cannot share that outstanding request. The usual case is a request that wants exclusive ownership while the outstanding one is only shared. These arrivals are parked on a second, deferred list. When the fill returns, the owner commands a promote. If deferred targets exist, they become the main list and the entry goes back to pending. It inherits the order and ready time of its first parked target, ready to be issued again. If there are none, the entry frees itself.

Target storage is two banks of `NT` slots. The roles of the banks (main and deferred) swap on promote, so no data is copied. `NT` also caps the total number of targets across both lists.

Top module: `miss_entry`

## Requirements
- R1: After reset `ent_valid`, `ent_busy`, `prom_ok` and `no_tgt_block` are 0 and `main_cnt` and `def_cnt` are 0.
- R2: When the entry is free, `alloc_valid` stores address, size, order, ready time (= `alloc_time`) and needs-exclusive (= `alloc_excl`). It writes main slot 0 as a CPU-side target (`rd_cpu`=1) carrying `alloc_time`, `alloc_order` and `alloc_excl`. It sets `main_cnt`=1 and `def_cnt`=0, and clears busy, `def_excl` and `inval_pend`. `alloc_valid` is ignored while the entry is valid.
- R3: While not in service, an accepted `tgt_valid` appends a CPU-side target to the main list. If `tgt_excl`=1, it also sets `ent_excl`.
- R4: While in service, an accepted target goes to the deferred list if `def_cnt`≠0, or `inval_pend`=1, or (`ent_excl`=0 and `tgt_excl`=1). Otherwise it is appended to the main list. `ent_excl` is not changed while in service.
- R5: A target placed on the deferred list with `tgt_excl`=1 sets `def_excl`.
- R6: `snp_valid` appends a memory-side target (`rd_cpu`=0, `rd_excl`=0) to the main list, but only while in service. Otherwise it has no effect.
- R7: `no_tgt_block` is 1 exactly when the entry is valid and `main_cnt`+`def_cnt`=`NT`. Any target or snoop arriving in that state is dropped.
- R8: A `promote` while in service with `def_cnt`≠0 has these effects:
  - The deferred targets become the main list in order, and `def_cnt`=0.
  - `ent_excl` takes `def_excl`, and `def_excl` and `inval_pend` are cleared.
  - `ent_order` takes the first promoted target's order.
  - `ent_ready` takes the larger of `now` and that target's time.
  - Busy clears, and `prom_ok` is 1 for the next cycle.
- R9: A `promote` while in service with `def_cnt`=0 frees the entry (`ent_valid`=0, counts 0), and `prom_ok` stays 0.
- R10: `free` on a valid entry clears `ent_valid`, busy and both counts.
- R11: Priority within a cycle is: `free`, then an effective `promote`, then all other commands. Other commands are ignored in a cycle where free or an effective promote acts. `promote` is ignored when not in service. `tgt_valid` wins over `snp_valid`. `issue` sets busy only when not busy.
- R12: A target arriving in the same cycle as `issue` is classified on the state before that edge: it is handled as not-in-service (main list, may set `ent_excl`). A snoop in that cycle is dropped.
- R13: `inval_set` on a valid entry sets `inval_pend`. The flag is cleared by allocate and by promote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now | input | TW | Current time, used for the ready time on promote |
| alloc_valid | input | 1 | Allocate the entry |
| alloc_addr | input | AW | Line address |
| alloc_size | input | SW | Request size |
| alloc_time | input | TW | Ready/arrival time of the first target |
| alloc_order | input | OW | Order stamp of the first target |
| alloc_excl | input | 1 | First target needs exclusive access |
| tgt_valid | input | 1 | Add a CPU-side target |
| tgt_time | input | TW | Arrival time of the target |
| tgt_order | input | OW | Order stamp of the target |
| tgt_excl | input | 1 | Target needs exclusive access |
| snp_valid | input | 1 | Add a memory-side (snoop) target |
| snp_time | input | TW | Arrival time of the snoop |
| snp_order | input | OW | Order stamp of the snoop |
| issue | input | 1 | Mark the entry in service |
| inval_set | input | 1 | Set the pending-invalidate flag |
| promote | input | 1 | Fill done: promote deferred targets or free |
| free | input | 1 | Release the entry |
| rd_def | input | 1 | Read port list select: 0 main, 1 deferred |
| rd_idx | input | $clog2(NT) | Read port slot index |
| ent_valid | output | 1 | Entry allocated |
| ent_busy | output | 1 | Entry in service |
| ent_addr | output | AW | Stored address |
| ent_size | output | SW | Stored size |
| ent_excl | output | 1 | Needs-exclusive flag |
| ent_order | output | OW | Entry order stamp |
| ent_ready | output | TW | Entry ready time |
| def_excl | output | 1 | Some deferred target needs exclusive |
| inval_pend | output | 1 | Pending-invalidate flag |
| main_cnt | output | $clog2(NT+1) | Targets on the main list |
| def_cnt | output | $clog2(NT+1) | Targets on the deferred list |
| no_tgt_block | output | 1 | Target capacity exhausted |
| prom_ok | output | 1 | One-cycle pulse: promote found deferred targets |
| rd_time | output | TW | Read port: target time |
| rd_order | output | OW | Read port: target order |
| rd_cpu | output | 1 | Read port: 1 CPU side, 0 memory side |
| rd_excl | output | 1 | Read port: target needs exclusive |

## Verification
The sharp coincidence is `issue` arriving in the same cycle as a new target or snoop. The entry is about to go in service, yet the arrival must still be judged by the state before the edge. That means the main list for the target, possibly setting needs-exclusive, and a dropped snoop. The bench drives these in one cycle, alongside `free` against `promote` and target against snoop. A behavioural queue model applies the priority rules and is compared with every output and every stored target slot after each clock. A long mixed random run then keeps producing such collisions.

// File: rtl/miss_entry.sv
module miss_entry #(
  parameter int AW = 32,
  parameter int SW = 8,
  parameter int TW = 16,
  parameter int OW = 16,
  parameter int NT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TW-1:0]            now,
  input  logic                     alloc_valid,
  input  logic [AW-1:0]            alloc_addr,
  input  logic [SW-1:0]            alloc_size,
  input  logic [TW-1:0]            alloc_time,
  input  logic [OW-1:0]            alloc_order,
  input  logic                     alloc_excl,
  input  logic                     tgt_valid,
  input  logic [TW-1:0]            tgt_time,
  input  logic [OW-1:0]            tgt_order,
  input  logic                     tgt_excl,
  input  logic                     snp_valid,
  input  logic [TW-1:0]            snp_time,
  input  logic [OW-1:0]            snp_order,
  input  logic                     issue,
  input  logic                     inval_set,
  input  logic                     promote,
  input  logic                     free,
  input  logic                     rd_def,
  input  logic [$clog2(NT)-1:0]    rd_idx,
  output logic                     ent_valid,
  output logic                     ent_busy,
  output logic [AW-1:0]            ent_addr,
  output logic [SW-1:0]            ent_size,
  output logic                     ent_excl,
  output logic [OW-1:0]            ent_order,
  output logic [TW-1:0]            ent_ready,
  output logic                     def_excl,
  output logic                     inval_pend,
  output logic [$clog2(NT+1)-1:0]  main_cnt,
  output logic [$clog2(NT+1)-1:0]  def_cnt,
  output logic                     no_tgt_block,
  output logic                     prom_ok,
  output logic [TW-1:0]            rd_time,
  output logic [OW-1:0]            rd_order,
  output logic                     rd_cpu,
  output logic                     rd_excl
);
  localparam int IW = $clog2(NT);
  localparam int CW = $clog2(NT + 1);

  logic [TW-1:0] st_time  [2][NT];
  logic [OW-1:0] st_order [2][NT];
  logic          st_cpu   [2][NT];
  logic          st_excl  [2][NT];
  logic          mb;

  logic [CW-1:0] total;
  logic          full, alloc_go, free_go, prom_go, live, tgt_go, snp_go, iss_go, to_def, wr_en;
  logic          wr_bank;
  logic [IW-1:0] wr_idx;
  logic [TW-1:0] wr_time, ft;
  logic [OW-1:0] wr_order;
  logic          wr_cpu, wr_excl;

  assign total    = main_cnt + def_cnt;
  assign full     = (total == CW'(NT));
  assign alloc_go = !ent_valid && alloc_valid;
  assign free_go  = ent_valid && free;
  assign prom_go  = ent_valid && !free && promote && ent_busy;
  assign live     = ent_valid && !free && !prom_go;
  assign tgt_go   = live && tgt_valid && !full;
  assign snp_go   = live && !tgt_valid && snp_valid && ent_busy && !full;
  assign iss_go   = live && issue && !ent_busy;
  assign to_def   = ent_busy && ((def_cnt != '0) || inval_pend || (!ent_excl && tgt_excl));
  assign wr_en    = alloc_go || tgt_go || snp_go;

  assign wr_bank  = (tgt_go && to_def) ? ~mb : mb;
  assign wr_idx   = alloc_go ? '0 : (tgt_go && to_def) ? IW'(def_cnt) : IW'(main_cnt);
  assign wr_time  = alloc_go ? alloc_time  : tgt_go ? tgt_time  : snp_time;
  assign wr_order = alloc_go ? alloc_order : tgt_go ? tgt_order : snp_order;
  assign wr_cpu   = !snp_go || alloc_go;
  assign wr_excl  = alloc_go ? alloc_excl : (tgt_go && tgt_excl);

  assign ft = st_time[~mb][0];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      st_time[wr_bank][wr_idx]  <= wr_time;
      st_order[wr_bank][wr_idx] <= wr_order;
      st_cpu[wr_bank][wr_idx]   <= wr_cpu;
      st_excl[wr_bank][wr_idx]  <= wr_excl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid  <= 1'b0;
      ent_busy   <= 1'b0;
      ent_addr   <= '0;
      ent_size   <= '0;
      ent_excl   <= 1'b0;
      ent_order  <= '0;
      ent_ready  <= '0;
      def_excl   <= 1'b0;
      inval_pend <= 1'b0;
      main_cnt   <= '0;
      def_cnt    <= '0;
      prom_ok    <= 1'b0;
      mb         <= 1'b0;
    end else begin
      prom_ok <= 1'b0;
      if (alloc_go) begin
        ent_valid  <= 1'b1;
        ent_busy   <= 1'b0;
        ent_addr   <= alloc_addr;
        ent_size   <= alloc_size;
        ent_excl   <= alloc_excl;
        ent_order  <= alloc_order;
        ent_ready  <= alloc_time;
        def_excl   <= 1'b0;
        inval_pend <= 1'b0;
        main_cnt   <= CW'(1);
        def_cnt    <= '0;
      end else if (free_go) begin
        ent_valid <= 1'b0;
        ent_busy  <= 1'b0;
        main_cnt  <= '0;
        def_cnt   <= '0;
      end else if (prom_go) begin
        if (def_cnt != '0) begin
          mb         <= ~mb;
          main_cnt   <= def_cnt;
          def_cnt    <= '0;
          ent_excl   <= def_excl;
          def_excl   <= 1'b0;
          inval_pend <= 1'b0;
          ent_busy   <= 1'b0;
          ent_order  <= st_order[~mb][0];
          ent_ready  <= (now > ft) ? now : ft;
          prom_ok    <= 1'b1;
        end else begin
          ent_valid <= 1'b0;
          ent_busy  <= 1'b0;
          main_cnt  <= '0;
          def_cnt   <= '0;
        end
      end else if (live) begin
        if (tgt_go) begin
          if (to_def) begin
            def_cnt <= def_cnt + CW'(1);
            if (tgt_excl) def_excl <= 1'b1;
          end else begin
            main_cnt <= main_cnt + CW'(1);
            if (!ent_busy && tgt_excl) ent_excl <= 1'b1;
          end
        end else if (snp_go) begin
          main_cnt <= main_cnt + CW'(1);
        end
        if (iss_go) ent_busy <= 1'b1;
        if (inval_set) inval_pend <= 1'b1;
      end
    end
  end

  assign no_tgt_block = ent_valid && full;

  logic rb;
  assign rb       = rd_def ? ~mb : mb;
  assign rd_time  = st_time[rb][rd_idx];
  assign rd_order = st_order[rb][rd_idx];
  assign rd_cpu   = st_cpu[rb][rd_idx];
  assign rd_excl  = st_excl[rb][rd_idx];
endmodule

// File: rtl/miss_entry_chk.sv
module miss_entry_chk #(
  parameter int NT = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ent_valid,
  input logic          ent_busy,
  input logic [CW-1:0] main_cnt,
  input logic [CW-1:0] def_cnt,
  input logic          no_tgt_block,
  input logic          prom_ok,
  input logic          alloc_valid,
  input logic          tgt_valid,
  input logic          snp_valid,
  input logic          promote,
  input logic          free
);
  a_r7_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(main_cnt) + int'(def_cnt)) <= NT);

  a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (no_tgt_block && !free && !promote) |=> ($stable(main_cnt) && $stable(def_cnt)));

  a_r2_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (!ent_valid && alloc_valid) |=> (ent_valid && !ent_busy && main_cnt == CW'(1) && def_cnt == '0));

  a_r4_def_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (def_cnt != '0) |-> ent_busy);

  a_r8_prom: assert property (@(posedge clk) disable iff (!rst_n)
    prom_ok |-> (ent_valid && !ent_busy && def_cnt == '0 && main_cnt != '0));

  a_r10_free: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && free) |=> (!ent_valid && main_cnt == '0));

  a_r6_snoop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !ent_busy && snp_valid && !tgt_valid && !free) |=> $stable(main_cnt));
endmodule

bind miss_entry miss_entry_chk #(.NT(NT), .CW($clog2(NT + 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_busy(ent_busy),
  .main_cnt(main_cnt), .def_cnt(def_cnt), .no_tgt_block(no_tgt_block),
  .prom_ok(prom_ok), .alloc_valid(alloc_valid), .tgt_valid(tgt_valid),
  .snp_valid(snp_valid), .promote(promote), .free(free)
);

// File: tb/miss_entry_tb.sv
module miss_entry_tb;
  localparam int AW = 32, SW = 8, TW = 16, OW = 16, NT = 4;
  localparam int IW = $clog2(NT), CW = $clog2(NT + 1);

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [TW-1:0] now = '0;
  logic alloc_valid = 0, alloc_excl = 0, tgt_valid = 0, tgt_excl = 0, snp_valid = 0;
  logic issue = 0, inval_set = 0, promote = 0, free = 0, rd_def = 0;
  logic [AW-1:0] alloc_addr = '0;
  logic [SW-1:0] alloc_size = '0;
  logic [TW-1:0] alloc_time = '0, tgt_time = '0, snp_time = '0;
  logic [OW-1:0] alloc_order = '0, tgt_order = '0, snp_order = '0;
  logic [IW-1:0] rd_idx = '0;
  logic ent_valid, ent_busy, ent_excl, def_excl, inval_pend, no_tgt_block, prom_ok, rd_cpu, rd_excl;
  logic [AW-1:0] ent_addr;
  logic [SW-1:0] ent_size;
  logic [OW-1:0] ent_order, rd_order;
  logic [TW-1:0] ent_ready, rd_time;
  logic [CW-1:0] main_cnt, def_cnt;

  miss_entry #(.AW(AW), .SW(SW), .TW(TW), .OW(OW), .NT(NT)) u_dut (.*);

  typedef struct { int t; int o; bit cpu; bit ex; } tgt_t;
  tgt_t mq[$], dq[$];
  bit mv, mbusy, mexcl, mdexcl, minval, mprom;
  int maddr, msize, morder, mready;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit done = 0;

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", phase, what, act, exp);
    end
  endtask

  task automatic model_step();
    tgt_t n;
    bit to_d;
    mprom = 0;
    if (!mv) begin
      if (alloc_valid) begin
        mv = 1; mbusy = 0; maddr = alloc_addr; msize = alloc_size;
        mexcl = alloc_excl; morder = alloc_order; mready = alloc_time;
        mdexcl = 0; minval = 0; mq = {}; dq = {};
        n.t = alloc_time; n.o = alloc_order; n.cpu = 1; n.ex = alloc_excl;
        mq.push_back(n);
      end
    end else if (free) begin
      mv = 0; mbusy = 0; mq = {}; dq = {};
    end else if (promote && mbusy) begin
      if (dq.size() != 0) begin
        mq = dq; dq = {};
        mexcl = mdexcl; mdexcl = 0; minval = 0; mbusy = 0;
        morder = mq[0].o;
        mready = (int'(now) > mq[0].t) ? int'(now) : mq[0].t;
        mprom = 1;
      end else begin
        mv = 0; mbusy = 0; mq = {}; dq = {};
      end
    end else begin
      if (tgt_valid) begin
        if (mq.size() + dq.size() < NT) begin
          n.t = tgt_time; n.o = tgt_order; n.cpu = 1; n.ex = tgt_excl;
          to_d = mbusy && (dq.size() != 0 || minval || (!mexcl && tgt_excl));
          if (to_d) begin
            dq.push_back(n);
            if (tgt_excl) mdexcl = 1;
          end else begin
            mq.push_back(n);
            if (!mbusy && tgt_excl) mexcl = 1;
          end
        end
      end else if (snp_valid && mbusy && mq.size() + dq.size() < NT) begin
        n.t = snp_time; n.o = snp_order; n.cpu = 0; n.ex = 0;
        mq.push_back(n);
      end
      if (issue) mbusy = 1;
      if (inval_set) minval = 1;
    end
  endtask

  task automatic compare();
    chk(ent_valid == mv, "valid", ent_valid, mv);
    chk(prom_ok == mprom, "prom_ok", prom_ok, mprom);
    chk(main_cnt == mq.size(), "main_cnt", main_cnt, mq.size());
    chk(def_cnt == dq.size(), "def_cnt", def_cnt, dq.size());
    chk(no_tgt_block == (mv && mq.size() + dq.size() == NT), "block", no_tgt_block,
        mv && mq.size() + dq.size() == NT);
    if (mv) begin
      chk(ent_busy == mbusy, "busy", ent_busy, mbusy);
      chk(ent_addr == maddr, "addr", ent_addr, maddr);
      chk(ent_size == msize, "size", ent_size, msize);
      chk(ent_excl == mexcl, "excl", ent_excl, mexcl);
      chk(ent_order == morder, "order", ent_order, morder);
      chk(ent_ready == mready, "ready", ent_ready, mready);
      chk(def_excl == mdexcl, "def_excl", def_excl, mdexcl);
      chk(inval_pend == minval, "inval", inval_pend, minval);
      for (int i = 0; i < mq.size(); i++) begin
        rd_def = 0; rd_idx = IW'(i); #0.5;
        chk(rd_time == mq[i].t && rd_order == mq[i].o && rd_cpu == mq[i].cpu && rd_excl == mq[i].ex,
            $sformatf("main[%0d] order", i), rd_order, mq[i].o);
      end
      for (int i = 0; i < dq.size(); i++) begin
        rd_def = 1; rd_idx = IW'(i); #0.5;
        chk(rd_time == dq[i].t && rd_order == dq[i].o && rd_cpu == dq[i].cpu && rd_excl == dq[i].ex,
            $sformatf("def[%0d] order", i), rd_order, dq[i].o);
      end
    end else begin
      chk(ent_busy == 0, "busy idle", ent_busy, 0);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    alloc_valid = 0; tgt_valid = 0; snp_valid = 0; issue = 0;
    inval_set = 0; promote = 0; free = 0;
    now = now + 1;
  endtask

  task automatic do_alloc(int a, int t, int o, bit e);
    alloc_valid = 1; alloc_addr = AW'(a); alloc_size = SW'(a & 63); alloc_time = TW'(t);
    alloc_order = OW'(o); alloc_excl = e; tick();
  endtask
  task automatic set_tgt(int t, int o, bit e);
    tgt_valid = 1; tgt_time = TW'(t); tgt_order = OW'(o); tgt_excl = e;
  endtask
  task automatic set_snp(int t, int o);
    snp_valid = 1; snp_time = TW'(t); snp_order = OW'(o);
  endtask
  task automatic do_tgt(int t, int o, bit e); set_tgt(t, o, e); tick(); endtask
  task automatic do_snp(int t, int o); set_snp(t, o); tick(); endtask
  task automatic do_issue(); issue = 1; tick(); endtask
  task automatic do_prom(); promote = 1; tick(); endtask
  task automatic do_free(); free = 1; tick(); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired act=1 exp=0");
    finish_run();
  end

  initial begin
    mv = 0; mbusy = 0; mprom = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1";
    compare();

    phase = "R2"; do_alloc(32'h1000, 20, 5, 0);
    do_alloc(32'h2000, 1, 1, 1);
    phase = "R3"; do_tgt(21, 6, 0); do_tgt(22, 7, 1);
    chk(ent_excl == 1, "R3 excl after exclusive target", ent_excl, 1);
    phase = "R11"; do_prom();
    phase = "R7"; do_issue(); do_tgt(23, 8, 0);
    chk(no_tgt_block == 1, "R7 block at capacity", no_tgt_block, 1);
    do_tgt(24, 9, 1); do_snp(25, 10);
    phase = "R9"; do_prom();
    chk(ent_valid == 0, "R9 freed without deferred", ent_valid, 0);

    phase = "R4"; do_alloc(32'h3040, 30, 40, 0); do_issue();
    phase = "R5"; do_tgt(31, 41, 1);
    chk(def_cnt == 1 && def_excl == 1, "R5 deferred exclusive", def_excl, 1);
    phase = "R4"; do_tgt(32, 42, 0);
    phase = "R6"; do_snp(33, 43);
    phase = "R8"; now = 10; do_prom();
    chk(ent_ready == 31 && ent_order == 41, "R8 inherited order", ent_order, 41);
    phase = "R8"; do_issue(); do_tgt(34, 44, 0); do_free();

    phase = "R13"; do_alloc(32'h5000, 50, 60, 1); do_issue();
    inval_set = 1; tick();
    phase = "R4"; do_tgt(51, 61, 0);
    phase = "R8"; now = 200; do_prom();
    chk(inval_pend == 0 && ent_ready == 200, "R8 ready from now", ent_ready, 200);
    do_free();

    phase = "R12"; do_alloc(32'h6000, 70, 80, 0);
    set_tgt(71, 81, 1); issue = 1; tick();
    chk(main_cnt == 2 && ent_excl == 1, "R12 target judged pre-issue", main_cnt, 2);
    do_free();
    do_alloc(32'h6100, 72, 82, 0);
    set_snp(73, 83); issue = 1; tick();
    phase = "R11"; set_tgt(74, 84, 1); set_snp(75, 85); tick();
    free = 1; promote = 1; tick();
    chk(ent_valid == 0, "R11 free beats promote", ent_valid, 0);
    phase = "R10"; do_alloc(32'h7000, 1, 2, 0); do_free();
    phase = "R6"; do_alloc(32'h7100, 3, 4, 0); do_snp(5, 6);
    chk(main_cnt == 1, "R6 snoop dropped when idle", main_cnt, 1);
    do_free();

    phase = "R11";
    for (int i = 0; i < 20000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 8) begin
        alloc_valid = 1; alloc_addr = AW'($urandom); alloc_size = SW'($urandom);
        alloc_time = TW'($urandom); alloc_order = OW'($urandom); alloc_excl = 1'($urandom);
      end
      if ($urandom_range(0, 3) == 0) set_tgt($urandom_range(0, 65535), $urandom_range(0, 65535), 1'($urandom));
      if ($urandom_range(0, 5) == 0) set_snp($urandom_range(0, 65535), $urandom_range(0, 65535));
      if ($urandom_range(0, 6) == 0) issue = 1;
      if ($urandom_range(0, 12) == 0) inval_set = 1;
      if ($urandom_range(0, 10) == 0) promote = 1;
      if ($urandom_range(0, 30) == 0) free = 1;
      if ($urandom_range(0, 40) == 0) now = TW'($urandom);
      tick();
    end
    finish_run();
  end
endmodule